// File: doc/BRIEF.md
# Frame-Synchronised Panel Power Sequencer

This block walks a display panel through its bring-up, sleep and wake procedures by issuing register writes to a serial write master. It also drives the panel's supply enable and its reset line. Steps come from an internal step table. Each step is one of the following: a register write, a delay in milliseconds, a delay in whole video frames, a level change on the reset or power pin, a jump, or an end marker. Frame delays count vertical-sync edge pulses from the timing generator. A delay of N frames therefore only finishes once N complete frames have gone by. The video timing must already be running when a sequence starts.

The controlling logic pulses `start_req` once to power the panel and turn it on. After that, `disable_req` puts the panel into standby and `enable_req` wakes it again. The wake procedure writes the standby-exit value and then jumps into the shared power-up and display-on steps. A request is dropped in three cases: it arrives while a sequence is running, it asks for the state the panel is already in, or it is an enable or disable that comes before bring-up. `seq_done` is high once a sequence has finished and stays high until the next sequence is accepted.

The write port follows valid/ready rules. `wr_valid` rises with `wr_addr` and `wr_data`. All three hold steady until the cycle in which `wr_ready` is also high, and that is the only cycle in which the write is taken. The sequencer does not move to its next step until this handshake has happened, so a slow master simply stalls the sequence.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is active and straight after it, `wr_valid`, `panel_pwr_en`, `panel_rst_line` and `seq_done` are all 0.
- R2: After `start_req`, `panel_rst_line` first goes to 1, then to 0, then back to 1, and then `panel_pwr_en` goes to 1. Each of these transitions is separated from the next by between 10*CYCLES_PER_MS and 10*CYCLES_PER_MS+4 clock cycles. The same spacing applies from the power enable to the rise of the first `wr_valid`.
- R3: Once `wr_valid` is 1, it stays 1 and `wr_addr`/`wr_data` stay unchanged until a cycle with `wr_ready` at 1. A write is taken only in such a cycle, and each write is taken exactly once.
- R4: Bring-up issues these 13 writes (address=data, hex), in this order: 07=0000, 12=1618, 11=2227, 13=61D1, 10=550C, 12=0C58, 07=0001, 07=0101, 76=2213, 1C=6650, 0B=33E1, 76=0000, 07=0103.
- R5: A wait of N frames finishes on the (N+1)-th `vsync_edge` pulse, counting pulses that arrive from the third cycle after the handshake of the preceding write. The write 12=0C58 follows a 5-frame wait, 07=0101 follows a 1-frame wait, and each write that follows a 2-frame wait follows 2 frames.
- R6: The write of 0x12 that comes after the 07=0000 write in the power steps rises at least 10*CYCLES_PER_MS cycles after the 07=0000 handshake.
- R7: A `disable_req` while the panel is on issues, in order: 0B=30E1, 07=0102, then a 2-frame wait, then 07=0000, 12=0000, 10=0100, 10=0001.
- R8: An `enable_req` while the panel is in standby issues 10=0000 and then the full list of R4, with the same waits.
- R9: No write, no pin change and no drop of `seq_done` follows any of these: a request that matches the current on/off state, any request made while a sequence is running, `start_req` after bring-up, or `enable_req`/`disable_req` before bring-up.
- R10: `seq_done` is 0 at every write handshake of a running sequence. It rises within 3 cycles after the final handshake, and `wr_valid` is 0 whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request for the full bring-up |
| enable_req | input | 1 | One-cycle request to leave standby |
| disable_req | input | 1 | One-cycle request to enter standby |
| vsync_edge | input | 1 | One-cycle pulse per vertical sync edge |
| wr_ready | input | 1 | Serial write master can take a write |
| wr_valid | output | 1 | A register write is offered |
| wr_addr | output | 8 | Panel register address |
| wr_data | output | 16 | Panel register value |
| panel_pwr_en | output | 1 | Panel supply enable |
| panel_rst_line | output | 1 | Panel reset line level |
| seq_done | output | 1 | Last sequence has completed |

## Verification
The hardest thing to observe from the ports is a frame wait, because the sequencer's wait state is invisible. The only sign is how many sync pulses go by between one write's handshake and the next write's valid. The bench runs a sync pulse train with random spacing and never places a pulse in the first cycles after a handshake. It counts the pulses seen before each write's valid rises, which makes the N+1 edge count exact even while `wr_ready` is being stalled at random. Requests sent in the middle of a sequence, and requests that match the current state, are mixed into a random sleep/wake walk to reach the ignore paths.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int PC_W = 6;

  typedef enum logic [2:0] {
    OP_WRITE  = 3'd0,
    OP_MS     = 3'd1,
    OP_FRAMES = 3'd2,
    OP_RSTPIN = 3'd3,
    OP_PWRPIN = 3'd4,
    OP_JUMP   = 3'd5,
    OP_END    = 3'd6
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [7:0]  addr;
    logic [15:0] arg;
  } step_t;

  localparam logic [PC_W-1:0] ENTRY_BRINGUP = 6'd0;
  localparam logic [PC_W-1:0] ENTRY_POWER   = 6'd8;
  localparam logic [PC_W-1:0] ENTRY_SLEEP   = 6'd26;
  localparam logic [PC_W-1:0] ENTRY_WAKE    = 6'd34;

  function automatic step_t wr(input logic [7:0] a, input logic [15:0] d);
    return '{op: OP_WRITE, addr: a, arg: d};
  endfunction

  function automatic step_t ctl(input op_e o, input logic [15:0] v);
    return '{op: o, addr: 8'h00, arg: v};
  endfunction

  // Step table; the power and display-on steps are shared by bring-up and wake.
  function automatic step_t seq_step(input logic [PC_W-1:0] idx);
    case (idx)
      6'd0:  return ctl(OP_RSTPIN, 16'd1);
      6'd1:  return ctl(OP_MS, 16'd10);
      6'd2:  return ctl(OP_RSTPIN, 16'd0);
      6'd3:  return ctl(OP_MS, 16'd10);
      6'd4:  return ctl(OP_RSTPIN, 16'd1);
      6'd5:  return ctl(OP_MS, 16'd10);
      6'd6:  return ctl(OP_PWRPIN, 16'd1);
      6'd7:  return ctl(OP_MS, 16'd10);
      6'd8:  return wr(8'h07, 16'h0000);
      6'd9:  return ctl(OP_MS, 16'd10);
      6'd10: return wr(8'h12, 16'h1618);
      6'd11: return wr(8'h11, 16'h2227);
      6'd12: return wr(8'h13, 16'h61D1);
      6'd13: return wr(8'h10, 16'h550C);
      6'd14: return ctl(OP_FRAMES, 16'd5);
      6'd15: return wr(8'h12, 16'h0C58);
      6'd16: return wr(8'h07, 16'h0001);
      6'd17: return ctl(OP_FRAMES, 16'd1);
      6'd18: return wr(8'h07, 16'h0101);
      6'd19: return ctl(OP_FRAMES, 16'd2);
      6'd20: return wr(8'h76, 16'h2213);
      6'd21: return wr(8'h1C, 16'h6650);
      6'd22: return wr(8'h0B, 16'h33E1);
      6'd23: return wr(8'h76, 16'h0000);
      6'd24: return wr(8'h07, 16'h0103);
      6'd25: return ctl(OP_END, 16'd0);
      6'd26: return wr(8'h0B, 16'h30E1);
      6'd27: return wr(8'h07, 16'h0102);
      6'd28: return ctl(OP_FRAMES, 16'd2);
      6'd29: return wr(8'h07, 16'h0000);
      6'd30: return wr(8'h12, 16'h0000);
      6'd31: return wr(8'h10, 16'h0100);
      6'd32: return wr(8'h10, 16'h0001);
      6'd33: return ctl(OP_END, 16'd0);
      6'd34: return wr(8'h10, 16'h0000);
      6'd35: return ctl(OP_JUMP, 16'(ENTRY_POWER));
      default: return ctl(OP_END, 16'd0);
    endcase
  endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
  import panel_seq_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  output step_t           step
);
  always_comb step = seq_step(pc);
endmodule

// File: rtl/panel_seq_timer.sv
module panel_seq_timer #(
  parameter int CYCLES_PER_MS = 100000,
  parameter int CNT_W         = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_ms,
  input  logic        load_frames,
  input  logic [15:0] amount,
  input  logic        vsync_edge,
  output logic        fin
);
  logic             active;
  logic             by_frame;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      by_frame <= 1'b0;
      cnt      <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load_ms) begin
        active   <= 1'b1;
        by_frame <= 1'b0;
        cnt      <= CNT_W'(amount) * CNT_W'(CYCLES_PER_MS) - CNT_W'(1);
      end else if (load_frames) begin
        // N frames: N+1 edges, so N remaining after the first
        active   <= 1'b1;
        by_frame <= 1'b1;
        cnt      <= CNT_W'(amount);
      end else if (active && (!by_frame || vsync_edge)) begin
        if (cnt == '0) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ms && load_frames)); // R5
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ms || load_frames) |-> !active); // R5
  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin); // R5
endmodule

// File: rtl/panel_wr_port.sv
module panel_wr_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              accepted
);
  assign accepted = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (issue) begin
      wr_valid <= 1'b1;
      wr_addr  <= issue_addr;
      wr_data  <= issue_data;
    end else if (accepted) begin
      wr_valid <= 1'b0;
    end
  end

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R3
  AST_ISSUE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !wr_valid); // R3
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import panel_seq_pkg::*;
#(
  parameter int CYCLES_PER_MS = 100000,
  parameter int CNT_W         = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        enable_req,
  input  logic        disable_req,
  input  logic        vsync_edge,
  input  logic        wr_ready,
  output logic        wr_valid,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        panel_pwr_en,
  output logic        panel_rst_line,
  output logic        seq_done
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WRITE, S_WAIT} state_e;

  state_e          state;
  logic [PC_W-1:0] pc;
  logic            powered;
  logic            panel_on;
  step_t           step;
  logic            issue;
  logic            accepted;
  logic            load_ms;
  logic            load_frames;
  logic            fin;

  panel_seq_rom u_rom (.pc(pc), .step(step));

  assign issue       = (state == S_EXEC) && (step.op == OP_WRITE);
  assign load_ms     = (state == S_EXEC) && (step.op == OP_MS);
  assign load_frames = (state == S_EXEC) && (step.op == OP_FRAMES);

  panel_wr_port #(.ADDR_W(8), .DATA_W(16)) u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .issue_addr(step.addr), .issue_data(step.arg),
    .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .accepted(accepted)
  );

  panel_seq_timer #(.CYCLES_PER_MS(CYCLES_PER_MS), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_ms(load_ms), .load_frames(load_frames),
    .amount(step.arg), .vsync_edge(vsync_edge), .fin(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      pc             <= ENTRY_BRINGUP;
      powered        <= 1'b0;
      panel_on       <= 1'b0;
      panel_pwr_en   <= 1'b0;
      panel_rst_line <= 1'b0;
      seq_done       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_req && !powered) begin
            pc       <= ENTRY_BRINGUP;
            powered  <= 1'b1;
            panel_on <= 1'b1;
            seq_done <= 1'b0;
            state    <= S_EXEC;
          end else if (powered && enable_req && !panel_on) begin
            pc       <= ENTRY_WAKE;
            panel_on <= 1'b1;
            seq_done <= 1'b0;
            state    <= S_EXEC;
          end else if (powered && disable_req && panel_on) begin
            pc       <= ENTRY_SLEEP;
            panel_on <= 1'b0;
            seq_done <= 1'b0;
            state    <= S_EXEC;
          end
        end
        S_EXEC: begin
          case (step.op)
            OP_WRITE:  state <= S_WRITE;
            OP_MS,
            OP_FRAMES: state <= S_WAIT;
            OP_RSTPIN: begin
              panel_rst_line <= step.arg[0];
              pc             <= pc + PC_W'(1);
            end
            OP_PWRPIN: begin
              panel_pwr_en <= step.arg[0];
              pc           <= pc + PC_W'(1);
            end
            OP_JUMP:   pc <= step.arg[PC_W-1:0];
            default: begin
              seq_done <= 1'b1;
              state    <= S_IDLE;
            end
          endcase
        end
        S_WRITE: begin
          if (accepted) begin
            pc    <= pc + PC_W'(1);
            state <= S_EXEC;
          end
        end
        default: begin
          if (fin) begin
            pc    <= pc + PC_W'(1);
            state <= S_EXEC;
          end
        end
      endcase
    end
  end

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !wr_valid); // R10
  AST_WRITE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (panel_pwr_en && panel_rst_line)); // R4
  AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> (state == S_IDLE) && !wr_valid); // R10
  AST_PINS_STILL_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && $past(seq_done)) |-> ($stable(panel_pwr_en) && $stable(panel_rst_line))); // R9
endmodule

// File: tb/test_panel_pwr_seq.sv
module test_panel_pwr_seq;
  localparam int CPM   = 20;
  localparam int MS10  = 10 * CPM;
  localparam int K_UP  = 0;
  localparam int K_OFF = 1;
  localparam int K_ON  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, enable_req = 1'b0, disable_req = 1'b0;
  logic vsync_edge = 1'b0, wr_ready = 1'b0;
  logic wr_valid, panel_pwr_en, panel_rst_line, seq_done;
  logic [7:0] wr_addr;
  logic [15:0] wr_data;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  panel_pwr_seq #(.CYCLES_PER_MS(CPM), .CNT_W(32)) i_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .enable_req(enable_req),
    .disable_req(disable_req), .vsync_edge(vsync_edge), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .panel_pwr_en(panel_pwr_en), .panel_rst_line(panel_rst_line), .seq_done(seq_done)
  );

  // ---------------- expected values ----------------
  function automatic logic [23:0] up_wr(input int i);
    case (i)
      0: return {8'h07, 16'h0000};  1: return {8'h12, 16'h1618};
      2: return {8'h11, 16'h2227};  3: return {8'h13, 16'h61D1};
      4: return {8'h10, 16'h550C};  5: return {8'h12, 16'h0C58};
      6: return {8'h07, 16'h0001};  7: return {8'h07, 16'h0101};
      8: return {8'h76, 16'h2213};  9: return {8'h1C, 16'h6650};
      10: return {8'h0B, 16'h33E1}; 11: return {8'h76, 16'h0000};
      default: return {8'h07, 16'h0103};
    endcase
  endfunction

  function automatic logic [23:0] off_wr(input int i);
    case (i)
      0: return {8'h0B, 16'h30E1}; 1: return {8'h07, 16'h0102};
      2: return {8'h07, 16'h0000}; 3: return {8'h12, 16'h0000};
      4: return {8'h10, 16'h0100}; default: return {8'h10, 16'h0001};
    endcase
  endfunction

  function automatic int up_fr(input int i);
    case (i) 5: return 6; 7: return 2; 8: return 3; default: return -1; endcase
  endfunction

  function automatic int exp_len(input int k);
    return (k == K_UP) ? 13 : (k == K_OFF) ? 6 : 14;
  endfunction

  function automatic logic [23:0] exp_wr(input int k, input int i);
    if (k == K_UP) return up_wr(i);
    if (k == K_OFF) return off_wr(i);
    return (i == 0) ? {8'h10, 16'h0000} : up_wr(i - 1);
  endfunction

  function automatic int exp_fr(input int k, input int i);
    if (k == K_UP) return up_fr(i);
    if (k == K_OFF) return (i == 2) ? 3 : -1;
    return (i == 0) ? -1 : up_fr(i - 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  int cycle = 0, since_hs = 100, vs_cnt = 0, last_hs = 0;
  int n = 0;
  logic [23:0] cap_wr[32];
  int cap_vs[32], cap_gap[32];
  bit cap_done[32];
  logic [23:0] rise_wr;
  logic prev_valid = 1'b0, prev_rst = 1'b0, prev_pwr = 1'b0;
  int ev_t[8], ev_k[8];
  int ev_n = 0, first_valid_t = -1;
  int cur_vs = 0, cur_gap = 0;

  always @(negedge clk) begin
    cycle++;
    since_hs++;
    if (rst_n) begin
      if (vsync_edge) vs_cnt++;
      if (panel_rst_line != prev_rst && ev_n < 8) begin
        ev_t[ev_n] = cycle; ev_k[ev_n] = panel_rst_line ? 0 : 1; ev_n++;
      end
      if (panel_pwr_en != prev_pwr && ev_n < 8) begin
        ev_t[ev_n] = cycle; ev_k[ev_n] = panel_pwr_en ? 2 : 3; ev_n++;
      end
      if (wr_valid && !prev_valid) begin
        rise_wr = {wr_addr, wr_data};
        cur_vs = vs_cnt;
        cur_gap = cycle - last_hs;
        if (first_valid_t < 0) first_valid_t = cycle;
      end
      if (wr_valid && wr_ready) begin
        check({wr_addr, wr_data} == rise_wr, "R3", "write changed before handshake",
              {wr_addr, wr_data}, rise_wr);
        if (n < 32) begin
          cap_wr[n] = {wr_addr, wr_data}; cap_vs[n] = cur_vs;
          cap_gap[n] = cur_gap; cap_done[n] = seq_done;
        end
        n++;
        vs_cnt = 0; since_hs = 0; last_hs = cycle;
      end
    end
    prev_valid = wr_valid; prev_rst = panel_rst_line; prev_pwr = panel_pwr_en;
  end

  // ---------------- random drivers ----------------
  bit run_vsync = 1'b0;
  initial begin
    int gap = 40, cnt = 0;
    void'($urandom(32'd1234));
    forever begin
      @(posedge clk); #1;
      wr_ready = ($urandom % 4) != 0;
      cnt++;
      if (run_vsync && cnt >= gap && since_hs >= 4) begin
        vsync_edge = 1'b1; cnt = 0; gap = 30 + ($urandom % 30);
      end else begin
        vsync_edge = 1'b0;
      end
    end
  end

  // ---------------- sequences ----------------
  task automatic pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) start_req = 1'b1;
    else if (which == 1) enable_req = 1'b1;
    else disable_req = 1'b1;
    @(posedge clk); #1;
    start_req = 1'b0; enable_req = 1'b0; disable_req = 1'b0;
  endtask

  task automatic run_seq(input int k, input string req, input bit poke);
    int len = exp_len(k), guard = 0;
    n = 0;
    pulse(k == K_UP ? 0 : (k == K_ON ? 1 : 2));
    if (poke) begin
      repeat (60) @(posedge clk);
      pulse(2);            // disable while busy: R9
      pulse(0);
    end
    while (!(n >= len && seq_done) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
    check(n == len, req, "write count", n, len);
    for (int i = 0; i < len && i < 32; i++) begin
      check(cap_wr[i] == exp_wr(k, i), req, $sformatf("write %0d", i), cap_wr[i], exp_wr(k, i));
      check(cap_done[i] == 1'b0, "R10", "done high at handshake", cap_done[i], 0);
      if (exp_fr(k, i) >= 0)
        check(cap_vs[i] == exp_fr(k, i), "R5", $sformatf("vsync edges before write %0d", i),
              cap_vs[i], exp_fr(k, i));
    end
    check(seq_done && !wr_valid, "R10", "done after last write", seq_done, 1);
  endtask

  task automatic ignored(input int which, input bit pre_start, input string what);
    n = 0;
    pulse(which);
    repeat (150) @(negedge clk);
    check(n == 0, "R9", {what, " writes"}, n, 0);
    if (pre_start)
      check(!panel_pwr_en && !panel_rst_line && !seq_done, "R9", {what, " pins"},
            {panel_pwr_en, panel_rst_line, seq_done}, 0);
    else
      check(seq_done && panel_pwr_en && panel_rst_line, "R9", {what, " state"},
            {panel_pwr_en, panel_rst_line, seq_done}, 7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycle);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit on;
    repeat (3) @(negedge clk);
    check(!wr_valid && !panel_pwr_en && !panel_rst_line && !seq_done, "R1", "in reset",
          {wr_valid, panel_pwr_en, panel_rst_line, seq_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!wr_valid && !panel_pwr_en && !panel_rst_line && !seq_done, "R1", "after reset",
          {wr_valid, panel_pwr_en, panel_rst_line, seq_done}, 0);
    run_vsync = 1'b1;
    ignored(1, 1'b1, "enable before start");
    ignored(2, 1'b1, "disable before start");

    run_seq(K_UP, "R4", 1'b1);
    check(ev_n == 4, "R2", "pin event count", ev_n, 4);
    check(ev_k[0] == 0 && ev_k[1] == 1 && ev_k[2] == 0 && ev_k[3] == 2, "R2", "pin order",
          {ev_k[0][3:0], ev_k[1][3:0], ev_k[2][3:0], ev_k[3][3:0]}, 16'h0102);
    for (int i = 1; i < 4; i++)
      check(ev_t[i] - ev_t[i-1] >= MS10 && ev_t[i] - ev_t[i-1] <= MS10 + 4, "R2",
            $sformatf("step spacing %0d", i), ev_t[i] - ev_t[i-1], MS10);
    check(first_valid_t - ev_t[3] >= MS10 && first_valid_t - ev_t[3] <= MS10 + 4, "R2",
          "power to first write", first_valid_t - ev_t[3], MS10);
    check(cap_gap[1] >= MS10, "R6", "10 ms after first write", cap_gap[1], MS10);

    ignored(1, 1'b0, "enable while on");
    ignored(0, 1'b0, "start after bring-up");
    run_seq(K_OFF, "R7", 1'b0);
    ignored(2, 1'b0, "disable in standby");
    run_seq(K_ON, "R8", 1'b0);
    check(cap_gap[2] >= MS10, "R6", "10 ms in wake", cap_gap[2], MS10);

    on = 1'b1;
    for (int it = 0; it < 6; it++) begin
      bit want = ($urandom % 2) != 0;
      if (want == on) ignored(want ? 1 : 2, 1'b0, "matching request");
      else begin
        run_seq(want ? K_ON : K_OFF, want ? "R8" : "R7", 1'b0);
        on = want;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule